// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Front End

This block sits between an 8-bit processor and a small memory subsystem made of one ROM and one RAM. The processor shares its low address byte and its data byte on one set of pins. At the start of each bus cycle it places the low address byte on those pins and raises an address strobe. The block holds that byte, joins it to five middle address lines taken straight from the processor, and uses the top three address lines to choose which memory answers.

Reads are active-low. While the read strobe is low and a device is selected, the block drives the stored byte onto the shared bus. At all other times the bus is released. Writes are also active-low. The RAM commits the byte that was on the bus during the low phase once the write strobe returns high. The shared bus is split into an input byte, an output byte and an output-enable, so the released state can be observed directly. The ROM image is fixed by a parameter at elaboration.

Top module: `mux_bus_mem`

## Requirements
- R1: While `ale` is high, the low address byte seen by the memories follows `adIn` at once. After `ale` falls, the value present on the last clock edge with `ale` high is held, and later changes on `adIn` have no effect on the address.
- R2: `addrHi[7:5]` = 3'b000 selects the ROM and 3'b001 selects the RAM. At most one device is selected at any time.
- R3: Both memories see the same 13-bit address {`addrHi[4:0]`, latched low byte}. The ROM is indexed by its low ROM_AW bits (default 5) and the RAM by its low RAM_AW bits (default 10), so `addrHi[1:0]` separates RAM locations.
- R4: While `rdN` and `wrN` are both high, `adOe` is 0.
- R5: With `rdN` low, `wrN` high and the ROM selected, `adOe` is 1 in the same cycle and `adOut` carries the ROM byte. In the default image, index 0x14 holds 0xDB, and every other index i holds (i*0x1D + 0x3C) mod 256. Address 0x0014 therefore reads 0xDB.
- R6: Codes 3'b010 to 3'b111 on `addrHi[7:5]` never cause a drive, and a write pulse under such a code changes no RAM location.
- R7: A write to the RAM takes effect on the first clock edge at which `wrN` is sampled high after being low. The byte stored is `adIn` from the last edge with `wrN` low. Data stored this way reads back with `rdN` low.
- R8: While `rdN` and `wrN` are both low, `adOe` is 0, and a write pulse that overlaps a low `rdN` stores nothing.
- R9: A write pulse with the ROM selected leaves the ROM contents and all RAM contents unchanged.
- R10: After reset, `adOe` is 0 and the held low address byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe; low byte transparent while high |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| adIn | input | 8 | Shared bus, processor-to-block direction |
| addrHi | input | 8 | Address lines 8 to 15 |
| adOut | output | 8 | Shared bus, block-to-processor direction |
| adOe | output | 1 | Drive enable for `adOut` |

## Verification
The hardest case to reach is a write pulse that overlaps a read strobe. A correct design must discard that write even though a clean rising edge on `wrN` follows it. The stimulus first stores a known byte in a RAM location. It then lowers both strobes together, with a different byte on the bus, releases them, and reads the location back. The bench also pulses writes under ROM and unmapped codes at RAM-aliasing low addresses, then reads the RAM, so that a stray write would show up at the ports.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef struct packed {
    logic romSel;
    logic ramSel;
    logic driveBus;
    logic ramWe;
    logic capLo;
    logic capWr;
  } strobes_t;

  localparam int DEF_ROM_AW = 5;
  localparam int DEF_ROM_DEPTH = 1 << DEF_ROM_AW;

  function automatic logic [DEF_ROM_DEPTH*8-1:0] defaultRomImage();
    logic [DEF_ROM_DEPTH*8-1:0] img;
    img = '0;
    for (int i = 0; i < DEF_ROM_DEPTH; i++) begin
      if (i == 20) img[i*8 +: 8] = 8'hDB;
      else img[i*8 +: 8] = 8'((i * 29 + 60) % 256);
    end
    return img;
  endfunction

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter logic [2:0] ROM_CODE = 3'b000,
  parameter logic [2:0] RAM_CODE = 3'b001
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ale,
  input  logic     rdN,
  input  logic     wrN,
  input  logic [2:0] devCode,
  output strobes_t stb
);

  logic prevWrN;
  logic wrClean;
  logic romHit;
  logic ramHit;
  logic wrRise;

  assign romHit = (devCode == ROM_CODE);
  assign ramHit = (devCode == RAM_CODE);
  assign wrRise = wrN && !prevWrN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWrN <= 1'b1;
      wrClean <= 1'b0;
    end else begin
      prevWrN <= wrN;
      if (!wrN) begin
        // a fresh low phase starts clean; any overlap with a read spoils it
        wrClean <= (prevWrN ? 1'b1 : wrClean) & rdN;
      end
    end
  end

  always_comb begin
    stb.romSel   = romHit;
    stb.ramSel   = ramHit;
    stb.driveBus = !rdN && wrN && (romHit || ramHit);
    stb.ramWe    = wrRise && wrClean && ramHit && rdN;
    stb.capLo    = ale;
    stb.capWr    = !wrN;
  end

  p_one_device_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.romSel, stb.ramSel}));

  p_idle_undriven_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && wrN) |-> !stb.driveBus);

  p_conflict_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |-> (!stb.driveBus && !stb.ramWe));

  p_write_after_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |-> ($past(!wrN) && wrN));

  p_unmapped_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (devCode[2:1] != 2'b00) |-> (!stb.driveBus && !stb.ramWe));

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int ROM_AW = 5,
  parameter int RAM_AW = 10,
  parameter logic [(8<<ROM_AW)-1:0] ROM_IMAGE = '0
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   stb,
  input  logic [7:0] busIn,
  input  logic [4:0] addrMid,
  output logic [7:0] busOut,
  output logic       busOe
);

  localparam int ADDR_W    = 13;
  localparam int ROM_DEPTH = 1 << ROM_AW;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [7:0] heldLo;
  logic [7:0] effLo;
  logic [ADDR_W-1:0] fullAddr;
  logic [ROM_AW-1:0] romIdx;
  logic [RAM_AW-1:0] ramIdx;
  logic [7:0] wrData;
  logic [7:0] romByte;
  logic [7:0] ramByte;
  logic [7:0] romMem [ROM_DEPTH];
  logic [7:0] ramMem [RAM_DEPTH];

  // address latch: transparent path while strobe high, register holds otherwise
  always_ff @(posedge clk) begin
    if (!rstN) heldLo <= 8'h00;
    else if (stb.capLo) heldLo <= busIn;
  end

  assign effLo    = stb.capLo ? busIn : heldLo;
  assign fullAddr = {addrMid, effLo};
  assign romIdx   = fullAddr[ROM_AW-1:0];
  assign ramIdx   = fullAddr[RAM_AW-1:0];

  generate
    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
      assign romMem[g] = ROM_IMAGE[g*8 +: 8];
    end
  endgenerate

  assign romByte = romMem[romIdx];

  always_ff @(posedge clk) begin
    if (!rstN) wrData <= 8'h00;
    else if (stb.capWr) wrData <= busIn;
  end

  always_ff @(posedge clk) begin
    if (stb.ramWe) ramMem[ramIdx] <= wrData;
  end

  assign ramByte = ramMem[ramIdx];

  always_comb begin
    busOe  = stb.driveBus;
    busOut = 8'h00;
    if (stb.driveBus) busOut = stb.romSel ? romByte : ramByte;
  end

  p_latch_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.capLo && $past(!stb.capLo)) |-> $stable(heldLo));

  p_ram_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |=> (ramMem[$past(ramIdx)] == $past(wrData)));

endmodule

// File: rtl/mux_bus_mem.sv
module mux_bus_mem
  import mbus_pkg::*;
#(
  parameter int ROM_AW = DEF_ROM_AW,
  parameter int RAM_AW = 10,
  parameter logic [(8<<ROM_AW)-1:0] ROM_IMAGE = defaultRomImage()
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ale,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [7:0] adIn,
  input  logic [7:0] addrHi,
  output logic [7:0] adOut,
  output logic       adOe
);

  strobes_t stb;

  mbus_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ale     (ale),
    .rdN     (rdN),
    .wrN     (wrN),
    .devCode (addrHi[7:5]),
    .stb     (stb)
  );

  mbus_datapath #(
    .ROM_AW    (ROM_AW),
    .RAM_AW    (RAM_AW),
    .ROM_IMAGE (ROM_IMAGE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busIn   (adIn),
    .addrMid (addrHi[4:0]),
    .busOut  (adOut),
    .busOe   (adOe)
  );

endmodule

// File: tb/mux_bus_mem_bench.sv
module mux_bus_mem_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ale = 1'b0;
  logic rdN = 1'b1;
  logic wrN = 1'b1;
  logic [7:0] adIn = 8'h00;
  logic [7:0] addrHi = 8'h00;
  logic [7:0] adOut;
  logic adOe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_mem u_mux_bus_mem (
    .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN),
    .adIn(adIn), .addrHi(addrHi), .adOut(adOut), .adOe(adOe)
  );

  function automatic logic [7:0] romExp(int i);
    int k = i % 32;
    if (k == 20) return 8'hDB;
    return 8'((k * 29 + 60) % 256);
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual oe/data=%h expected=%h", req, act, exp);
    end
  endtask

  // pulse the address strobe, then scramble the shared bus
  task automatic setAddr(logic [15:0] a);
    @(negedge clk); addrHi = a[15:8]; adIn = a[7:0]; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); adIn = ~a[7:0];
  endtask

  task automatic readExp(string req, logic [7:0] exp);
    @(negedge clk); rdN = 1'b0;
    #1 check(req, {adOe, adOut}, {1'b1, exp});
    @(negedge clk); rdN = 1'b1;
  endtask

  task automatic writeCyc(logic [7:0] d);
    @(negedge clk); wrN = 1'b0; adIn = d;
    @(negedge clk); wrN = 1'b1; adIn = ~d;
    @(negedge clk);
  endtask

  task automatic testReset();
    #1 check("R10 oe after reset", {adOe, 8'h00}, 9'h000);
    // read with no strobe: held byte 0, mid 0 -> ROM index 0
    @(negedge clk); addrHi = 8'h00; rdN = 1'b0;
    #1 check("R10 held byte zero", {adOe, adOut}, {1'b1, romExp(0)});
    @(negedge clk); rdN = 1'b1;
  endtask

  task automatic testRomRead();
    setAddr(16'h0014);
    #1 check("R4 idle undriven", {adOe, 8'h00}, 9'h000);
    readExp("R5 rom 0014", 8'hDB);
    setAddr(16'h0009);
    readExp("R5 rom 0009", romExp(9));
    setAddr(16'h001F);
    readExp("R5 rom 001F", romExp(31));
  endtask

  task automatic testLatch();
    setAddr(16'h0014);
    @(negedge clk); adIn = 8'h00; rdN = 1'b0;
    #1 check("R1 holds after strobe", {adOe, adOut}, {1'b1, 8'hDB});
    @(negedge clk); rdN = 1'b1;
    @(negedge clk); ale = 1'b1; adIn = 8'h03; rdN = 1'b0;
    #1 check("R1 transparent", {adOe, adOut}, {1'b1, romExp(3)});
    adIn = 8'h07;
    #1 check("R1 follows bus", {adOe, adOut}, {1'b1, romExp(7)});
    @(negedge clk); ale = 1'b0; rdN = 1'b1; adIn = 8'h11;
    readExp("R1 keeps last captured", romExp(7));
  endtask

  task automatic testRam();
    setAddr(16'h2005); writeCyc(8'hA1);
    setAddr(16'h2105); writeCyc(8'h5E);
    setAddr(16'h2005); readExp("R7 ram 2005", 8'hA1);
    setAddr(16'h2105); readExp("R3 ram 2105 distinct", 8'h5E);
    setAddr(16'h23FF); writeCyc(8'h3C);
    readExp("R7 ram top", 8'h3C);
  endtask

  task automatic testUnmapped();
    for (int c = 2; c < 8; c++) begin
      setAddr({3'(c), 13'h0005});
      @(negedge clk); rdN = 1'b0;
      #1 check("R6 unmapped undriven", {adOe, 8'h00}, 9'h000);
      @(negedge clk); rdN = 1'b1;
      writeCyc(8'hEE);
    end
    setAddr(16'h2005);
    readExp("R6 ram untouched", 8'hA1);
    setAddr(16'h0005);
    readExp("R2 rom select", romExp(5));
  endtask

  task automatic testConflict();
    setAddr(16'h2005);
    @(negedge clk); rdN = 1'b0; wrN = 1'b0; adIn = 8'h77;
    #1 check("R8 conflict undriven", {adOe, 8'h00}, 9'h000);
    @(negedge clk); rdN = 1'b1;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk);
    readExp("R8 no write", 8'hA1);
  endtask

  task automatic testRomWrite();
    setAddr(16'h0014); writeCyc(8'h12);
    readExp("R9 rom unchanged", 8'hDB);
    setAddr(16'h2014); writeCyc(8'h90);
    setAddr(16'h0014); writeCyc(8'h12);
    setAddr(16'h2014); readExp("R9 ram unchanged", 8'h90);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRomRead();
    testLatch();
    testRam();
    testUnmapped();
    testConflict();
    testRomWrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule